// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This unit is a SIMD datapath stage. It takes two packed vectors of unsigned bytes and forms the absolute difference of every byte pair. It adds each run of eight differences and writes the sum as a 16-bit unsigned word at the bottom of the 64-bit lane that holds those bytes. All other bits of that lane are cleared.

The unit works at two widths. The full width covers 256 bits and four lanes. The half width covers 128 bits and two lanes. The half width has two ways to treat the upper 128 bits of the destination: it either copies them from the prior destination value presented with the operands, or it forces them to zero. A one-cycle strobe presents one operation. The result and its valid flag appear one clock later. A new operation can be accepted on every cycle.

The mode select is decoded into a named enumeration, one name per encoding:

| Name | Encoding | Meaning |
|---|---|---|
| MERGE128 | 2'b00 | Half width, upper bits kept |
| ZERO128 | 2'b01 | Half width, upper bits cleared |
| FULL256 | 2'b10 | Full width |
| FULL256_ALT | 2'b11 | Same as FULL256 |

The unit has no state machine. It holds a single output register stage.

Top module: `sad_unit`

## Requirements
- R1: Each byte term is the unsigned magnitude |a − b| of the matching bytes of src_a and src_b. The result is the same when the two operands are swapped.
- R2: The differences of bytes 0–7 add into result[15:0], and the differences of bytes 8–15 add into result[79:64].
- R3: At full width, bytes 16–23 add into result[143:128], and bytes 24–31 add into result[207:192].
- R4: Inside the active width, every bit of a 64-bit lane above its low 16-bit sum word is zero. For example, bits 63:16 and 127:80 are zero.
- R5: With mode 2'b00, result[255:128] equals dst_prev[255:128] as sampled with the operation. src bytes 16–31 have no effect.
- R6: With mode 2'b01, result[255:128] is zero. src bytes 16–31 have no effect.
- R7: Modes 2'b10 and 2'b11 both give the full-width result.
- R8: Each sum word is an unsigned 16-bit value that never exceeds 2040. This maximum comes from eight differences of 255, and the sum does not wrap.
- R9: An operation strobed with in_valid in one cycle drives out_valid high and its result in the next cycle. Back-to-back strobes give back-to-back results.
- R10: A synchronous reset drives out_valid low on the next clock.
- R11: In a cycle after one where in_valid was low, out_valid is low and result keeps the last value produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Width and upper-half select |
| src_a | input | 256 | First packed byte operand |
| src_b | input | 256 | Second packed byte operand |
| dst_prev | input | 256 | Prior destination value for the keep mode |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 256 | Packed sum words |

## Verification
The bench builds the unit with its default parameters: four 64-bit lanes, eight bytes per group and 16-bit sum words. This is the only setting where the fixed bit positions in the requirements apply. These parameters bring several cases within reach:
- the all-ones against all-zeros extreme, which reaches the 2040 ceiling in every lane;
- operand swaps, which test the magnitude rather than a wrapped difference;
- both 128-bit sub-modes with busy upper source bytes and a busy prior destination;
- the spare mode code 2'b11.

// File: rtl/sad_pkg.sv
package sad_pkg;

    typedef enum logic [1:0] {
        SAD_M_MERGE128   = 2'b00,
        SAD_M_ZERO128    = 2'b01,
        SAD_M_FULL256    = 2'b10,
        SAD_M_FULL256_ALT = 2'b11
    } sad_mode_e;

    localparam int SAD_BYTE_W = 8;

    // true when the mode selects the full vector width (R7)
    function automatic logic sad_is_full(input sad_mode_e m);
        logic full;
        unique case (m)
            SAD_M_MERGE128:    full = 1'b0;
            SAD_M_ZERO128:     full = 1'b0;
            SAD_M_FULL256:     full = 1'b1;
            SAD_M_FULL256_ALT: full = 1'b1;
            default:           full = 1'b1;
        endcase
        return full;
    endfunction

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    output logic [BYTE_W-1:0] d_o
);
    // unsigned magnitude of the difference (R1)
    logic a_ge_b;

    always_comb begin
        a_ge_b = (a_i >= b_i);
        if (a_ge_b) begin
            d_o = a_i - b_i;
        end else begin
            d_o = b_i - a_i;
        end
    end
endmodule

// File: rtl/sad_group_sum.sv
module sad_group_sum #(
    parameter int GROUP_N = 8,
    parameter int IN_W    = 8,
    localparam int LEVELS = $clog2(GROUP_N),
    localparam int OUT_W  = IN_W + LEVELS
) (
    input  logic [GROUP_N*IN_W-1:0] terms_i,
    output logic [OUT_W-1:0]        sum_o
);
    // balanced adder tree, one generate block per level; width grows to
    // hold GROUP_N * (2**IN_W - 1) without wrap (R8)
    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int N = GROUP_N >> lv;
        logic [OUT_W-1:0] s [N];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
                assign s[i] = {{(OUT_W-IN_W){1'b0}}, terms_i[i*IN_W +: IN_W]};
            end
        end else begin : g_node
            for (genvar i = 0; i < N; i++) begin : g_add
                assign s[i] = g_lvl[lv-1].s[2*i] + g_lvl[lv-1].s[2*i+1];
            end
        end
    end

    assign sum_o = g_lvl[LEVELS].s[0];
endmodule

// File: rtl/sad_lane_pack.sv
module sad_lane_pack #(
    parameter int LANE_W = 64,
    parameter int SUM_W  = 16,
    parameter int RAW_W  = 11
) (
    input  logic [RAW_W-1:0]  raw_i,
    output logic [LANE_W-1:0] lane_o
);
    // sum word in the low bits, the rest of the lane cleared (R4)
    logic [SUM_W-1:0] word;

    assign word   = {{(SUM_W-RAW_W){1'b0}}, raw_i};
    assign lane_o = {{(LANE_W-SUM_W){1'b0}}, word};
endmodule

// File: rtl/sad_unit.sv
module sad_unit
    import sad_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 64,
    parameter int SUM_W     = 16,
    localparam int BYTES_PER_LANE = LANE_W / SAD_BYTE_W,
    localparam int DATA_W         = NUM_LANES * LANE_W,
    localparam int HALF_W         = DATA_W / 2,
    localparam int RAW_W          = SAD_BYTE_W + $clog2(BYTES_PER_LANE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_prev,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    sad_mode_e         mode_e;
    logic [DATA_W-1:0] lanes_all;
    logic [DATA_W-1:0] next_result;
    logic              out_valid_q;
    logic [DATA_W-1:0] result_q;

    assign mode_e = sad_mode_e'(mode);

    // one datapath slice per 64-bit lane (R1, R2, R3)
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] diffs;
        logic [RAW_W-1:0]  raw_sum;
        logic [LANE_W-1:0] packed_lane;

        for (genvar b = 0; b < BYTES_PER_LANE; b++) begin : g_byte
            sad_absdiff #(
                .BYTE_W(SAD_BYTE_W)
            ) u_absdiff (
                .a_i(src_a[l*LANE_W + b*SAD_BYTE_W +: SAD_BYTE_W]),
                .b_i(src_b[l*LANE_W + b*SAD_BYTE_W +: SAD_BYTE_W]),
                .d_o(diffs[b*SAD_BYTE_W +: SAD_BYTE_W])
            );
        end

        sad_group_sum #(
            .GROUP_N(BYTES_PER_LANE),
            .IN_W   (SAD_BYTE_W)
        ) u_sum (
            .terms_i(diffs),
            .sum_o  (raw_sum)
        );

        sad_lane_pack #(
            .LANE_W(LANE_W),
            .SUM_W (SUM_W),
            .RAW_W (RAW_W)
        ) u_pack (
            .raw_i (raw_sum),
            .lane_o(packed_lane)
        );

        assign lanes_all[l*LANE_W +: LANE_W] = packed_lane;
    end

    // upper-half selection by mode (R5, R6, R7)
    always_comb begin
        next_result[HALF_W-1:0] = lanes_all[HALF_W-1:0];
        unique case (mode_e)
            SAD_M_MERGE128:    next_result[DATA_W-1:HALF_W] = dst_prev[DATA_W-1:HALF_W];
            SAD_M_ZERO128:     next_result[DATA_W-1:HALF_W] = '0;
            SAD_M_FULL256,
            SAD_M_FULL256_ALT: next_result[DATA_W-1:HALF_W] = lanes_all[DATA_W-1:HALF_W];
            default:           next_result[DATA_W-1:HALF_W] = lanes_all[DATA_W-1:HALF_W];
        endcase
    end

    // output stage (R9, R10, R11)
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && !rst) begin
            result_q <= next_result;
        end
    end

    assign out_valid = out_valid_q;
    assign result    = result_q;

endmodule

// File: rtl/sad_unit_chk.sv
module sad_unit_chk #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 64,
    parameter int SUM_W     = 16,
    localparam int DATA_W   = NUM_LANES * LANE_W,
    localparam int HALF_W   = DATA_W / 2,
    localparam int MAX_SUM  = (LANE_W / 8) * 255
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] dst_prev,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    p_valid_next_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_keep_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=> (result[DATA_W-1:HALF_W] == $past(dst_prev[DATA_W-1:HALF_W])));

    p_clear_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=> (result[DATA_W-1:HALF_W] == '0));

    for (genvar l = 0; l < NUM_LANES / 2; l++) begin : g_low
        p_lane_zero_r4: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (result[l*LANE_W + SUM_W +: LANE_W - SUM_W] == '0));

        p_sum_bound_r8: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (result[l*LANE_W +: SUM_W] <= SUM_W'(MAX_SUM)));
    end

endmodule

bind sad_unit sad_unit_chk #(
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W),
    .SUM_W    (SUM_W)
) u_sad_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .mode     (mode),
    .dst_prev (dst_prev),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/sad_unit_tb_top.sv
module sad_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   mode;
    logic [255:0] src_a;
    logic [255:0] src_b;
    logic [255:0] dst_prev;
    logic         out_valid;
    logic [255:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sad_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode     (mode),
        .src_a    (src_a),
        .src_b    (src_b),
        .dst_prev (dst_prev),
        .out_valid(out_valid),
        .result   (result)
    );

    // expected value from the requirements
    function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                           input logic [255:0] p, input logic [1:0] m);
        logic [255:0] r;
        int lanes;
        r = '0;
        lanes = (m[1]) ? 4 : 2;
        for (int l = 0; l < lanes; l++) begin
            int s;
            s = 0;
            for (int k = 0; k < 8; k++) begin
                int x;
                int y;
                x = a[(l*8+k)*8 +: 8];
                y = b[(l*8+k)*8 +: 8];
                s += (x >= y) ? (x - y) : (y - x);
            end
            r[l*64 +: 16] = 16'(s);
        end
        if (m == 2'b00) r[255:128] = p[255:128];
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [255:0] a, input logic [255:0] b,
                         input logic [255:0] p, input logic [1:0] m);
        in_valid = 1'b1;
        src_a    = a;
        src_b    = b;
        dst_prev = p;
        mode     = m;
    endtask

    task automatic run_one(input string req, input string what, input logic [255:0] a,
                           input logic [255:0] b, input logic [255:0] p, input logic [1:0] m);
        @(negedge clk);
        drive(a, b, p, m);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {what, " valid"}, 256'(out_valid), 256'(1));
        check(req, what, result, model(a, b, p, m));
    endtask

    function automatic logic [255:0] pattern(input int seed);
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'((seed * 37 + i * 91 + i * i * 13) & 255);
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        mode = 2'b00;
        src_a = '0;
        src_b = '0;
        dst_prev = '0;
        repeat (3) @(negedge clk);
        check("R10", "out_valid in reset", 256'(out_valid), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R10", "out_valid after reset", 256'(out_valid), 256'(0));
    endtask

    task automatic t_low_groups();
        // R2: byte groups 0-7 and 8-15 land in bits 15:0 and 79:64
        logic [255:0] a;
        logic [255:0] b;
        a = '0;
        b = '0;
        a[7:0] = 8'd10;
        b[15:8] = 8'd3;
        a[71:64] = 8'd200;
        b[71:64] = 8'd50;
        run_one("R2", "low groups", a, b, '0, 2'b10);
        check("R2", "word0", 256'(result[15:0]), 256'(13));
        check("R2", "word1", 256'(result[79:64]), 256'(150));
    endtask

    task automatic t_swap();
        logic [255:0] a;
        logic [255:0] b;
        logic [255:0] r1;
        a = pattern(3);
        b = pattern(11);
        run_one("R1", "a,b", a, b, '0, 2'b10);
        r1 = result;
        run_one("R1", "b,a", b, a, '0, 2'b10);
        check("R1", "swap equal", result, r1);
    endtask

    task automatic t_max();
        run_one("R8", "max", {256{1'b1}}, '0, '0, 2'b10);
        for (int l = 0; l < 4; l++) check("R8", "lane at 2040", 256'(result[l*64 +: 16]), 256'(2040));
    endtask

    task automatic t_full();
        run_one("R3", "full 2'b10", pattern(5), pattern(22), pattern(9), 2'b10);
        check("R4", "lane fill zero", 256'(result[63:16] | result[127:80] | result[191:144] | result[255:208]), 256'(0));
    endtask

    task automatic t_alt();
        run_one("R7", "full 2'b11", pattern(7), pattern(1), pattern(4), 2'b11);
    endtask

    task automatic t_merge();
        run_one("R5", "keep upper", pattern(2), pattern(8), pattern(30), 2'b00);
        check("R5", "upper copy", 256'(result[255:128]), 256'(dst_prev[255:128]));
    endtask

    task automatic t_zero_upper();
        run_one("R6", "clear upper", pattern(12), pattern(40), {256{1'b1}}, 2'b01);
        check("R6", "upper zero", 256'(result[255:128]), 256'(0));
    endtask

    task automatic t_hold();
        logic [255:0] last;
        run_one("R11", "before idle", pattern(6), pattern(16), '0, 2'b10);
        last = result;
        src_a = pattern(50);
        src_b = pattern(51);
        repeat (3) @(negedge clk);
        check("R11", "idle valid low", 256'(out_valid), 256'(0));
        check("R11", "idle result held", result, last);
    endtask

    task automatic t_b2b();
        logic [255:0] e1;
        logic [255:0] e2;
        e1 = model(pattern(60), pattern(61), pattern(62), 2'b01);
        e2 = model(pattern(63), pattern(64), pattern(65), 2'b00);
        @(negedge clk);
        drive(pattern(60), pattern(61), pattern(62), 2'b01);
        @(negedge clk);
        check("R9", "b2b first", result, e1);
        drive(pattern(63), pattern(64), pattern(65), 2'b00);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "b2b valid", 256'(out_valid), 256'(1));
        check("R9", "b2b second", result, e2);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        drive(pattern(70), pattern(71), '0, 2'b10);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        check("R10", "reset beats strobe", 256'(out_valid), 256'(0));
    endtask

    initial begin
        t_reset();
        t_low_groups();
        t_swap();
        t_max();
        t_full();
        t_alt();
        t_merge();
        t_zero_upper();
        t_hold();
        t_b2b();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule